// File: doc/BRIEF.md
# USB Host Port State Controller

This block tracks the host side of a single USB port: whether the port is switched on in host mode, whether a device is plugged in, and whether the bus is running or suspended. It watches the DP and DM line levels, an enable bit, a host/device mode select, a flag that says VBUS is powered, and a bit that turns start-of-frame generation on or off. From these it keeps a four-state machine and reports the current state.

A device is recognised by the pull-up it places on one of the data lines. The line levels are synchronised, and a level change must persist for a set number of cycles before it is believed. Attach and detach produce single-cycle event pulses. While the bus is active, a frame timer issues a one-cycle tick every frame period (1 ms by default). The bus is suspended only by withholding those ticks, which happens when the start-of-frame enable bit is cleared.

Top module: `usbh_port_fsm`

## Requirements
- R1: While reset is asserted and afterwards, `state_o` reads 0 (Reset) and `connect_o`, `disconnect_o` and `sof_tick_o` are 0. The state encoding is Reset=0, Idle=1, Ready=2, Suspend=3. The machine stays in Reset until `enable_i`=1 and `dev_mode_i`=0.
- R2: When `enable_i`=1 and `dev_mode_i`=0, Reset moves to Idle on the next clock edge. When `enable_i`=0 or `dev_mode_i`=1, every state returns to Reset on the next edge. This return raises no event pulse, and no SOF tick is produced while in Reset.
- R3: In Idle with `vbus_req_i`=0, line activity is ignored and the state stays Idle.
- R4: The line counts as occupied when DP=1 or DM=1 (either line alone is enough), and as free when both are 0. Idle with `vbus_req_i`=1 and an occupied line moves to Ready. Ready or Suspend with a free line moves to Idle.
- R5: DP and DM each pass through two flip-flops. The combined line level must differ from the accepted level on `DEB_CYCLES` consecutive clock edges before it is accepted. A pin change that is held steady therefore changes the state on the (DEB_CYCLES+3)-th edge after it. A pulse that lasts fewer than `DEB_CYCLES` cycles is ignored.
- R6: Ready with `sof_en_i`=0 moves to Suspend on the next edge. Suspend with `sof_en_i`=1 moves back to Ready on the next edge.
- R7: `sof_tick_o` is high for one cycle only in Ready. The frame counter restarts at each entry to Ready, so the first tick comes TICKS_PER_FRAME-1 edges after the entry edge, and later ticks come every TICKS_PER_FRAME cycles. No tick is produced in Idle, Suspend or Reset.
- R8: `connect_o` is high for exactly the first cycle of a Ready entered from Idle. `disconnect_o` is high for exactly the first cycle of an Idle entered from Ready or Suspend.
- R9: Priority when several conditions arrive together: leaving host operation (R2) beats a detach, and a detach beats a change of `sof_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Port enable |
| dev_mode_i | input | 1 | Mode select: 0 = host, 1 = device (holds the machine in Reset) |
| vbus_req_i | input | 1 | VBUS is powered; arms attach detection |
| sof_en_i | input | 1 | Start-of-frame generation enable |
| dp_i | input | 1 | DP line level, asynchronous |
| dm_i | input | 1 | DM line level, asynchronous |
| state_o | output | 2 | Current state (0 Reset, 1 Idle, 2 Ready, 3 Suspend) |
| connect_o | output | 1 | One-cycle attach event |
| disconnect_o | output | 1 | One-cycle detach event |
| sof_tick_o | output | 1 | One-cycle frame tick while Ready |

## Verification
A detach and a clear of the start-of-frame enable can both be due on the same clock edge. The bench provokes this by freeing the lines in Ready and counting edges until the debounce window is about to close, then clearing `sof_en_i` just before that decisive edge. The result is judged correct only if the state goes straight to Idle with a `disconnect_o` pulse and does not pass through Suspend. A second case drops `enable_i` while the port is attached and expects Reset with no detach pulse and no further ticks.

// File: rtl/usbh_port_pkg.sv
package usbh_port_pkg;

  typedef enum logic [1:0] {
    ST_RESET   = 2'd0,
    ST_IDLE    = 2'd1,
    ST_READY   = 2'd2,
    ST_SUSPEND = 2'd3
  } port_state_t;

  // true when a stable-difference counter has seen its last allowed edge
  function automatic logic window_full(int unsigned cnt, int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  // true on the last cycle of a frame period
  function automatic logic frame_end(int unsigned cnt, int unsigned period);
    return cnt == (period - 1);
  endfunction

  // next-state rule; disable beats detach beats the SOF-enable bit
  function automatic port_state_t next_port_state(port_state_t cur, logic run_ok,
                                                  logic vbus, logic sof_en,
                                                  logic present);
    port_state_t nxt;
    nxt = cur;
    if (!run_ok) begin
      nxt = ST_RESET;
    end else begin
      case (cur)
        ST_RESET:   nxt = ST_IDLE;
        ST_IDLE:    nxt = (vbus && present) ? ST_READY : ST_IDLE;
        ST_READY:   nxt = !present ? ST_IDLE : (!sof_en ? ST_SUSPEND : ST_READY);
        ST_SUSPEND: nxt = !present ? ST_IDLE : (sof_en ? ST_READY : ST_SUSPEND);
        default:    nxt = ST_RESET;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/usbh_sync2.sv
module usbh_sync2 #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end

endmodule

// File: rtl/usbh_line_filter.sv
module usbh_line_filter #(
  parameter int unsigned DEB_CYCLES = 4800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o
);
  import usbh_port_pkg::*;

  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          differs;

  assign differs = (raw_i != level_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (window_full(32'(cnt_q), DEB_CYCLES)) begin
      cnt_q   <= '0;
      level_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/usbh_frame_timer.sv
module usbh_frame_timer #(
  parameter int unsigned TICKS_PER_FRAME = 48000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  import usbh_port_pkg::*;

  localparam int unsigned FW = $clog2(TICKS_PER_FRAME + 1);

  logic [FW-1:0] cnt_q;
  logic          at_end;

  assign at_end = frame_end(32'(cnt_q), TICKS_PER_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (at_end)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && at_end;

endmodule

// File: rtl/usbh_port_fsm.sv
module usbh_port_fsm #(
  parameter int unsigned TICKS_PER_FRAME = 48000,
  parameter int unsigned DEB_CYCLES      = 4800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       dev_mode_i,
  input  logic       vbus_req_i,
  input  logic       sof_en_i,
  input  logic       dp_i,
  input  logic       dm_i,
  output logic [1:0] state_o,
  output logic       connect_o,
  output logic       disconnect_o,
  output logic       sof_tick_o
);
  import usbh_port_pkg::*;

  // named internal events, visible to the bound checker
  logic [1:0]  lines_sync;
  logic        raw_line;
  logic        line_present;
  logic        run_ok;
  logic        attach_evt;
  logic        detach_evt;
  port_state_t state_q, state_d;
  logic        connect_q, disconnect_q;

  usbh_sync2 #(.WIDTH(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({dp_i, dm_i}),
    .sync_o  (lines_sync)
  );

  assign raw_line = |lines_sync;

  usbh_line_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw_line),
    .level_o (line_present)
  );

  assign run_ok  = enable_i && !dev_mode_i;
  assign state_d = next_port_state(state_q, run_ok, vbus_req_i, sof_en_i, line_present);

  assign attach_evt = (state_q == ST_IDLE) && (state_d == ST_READY);
  assign detach_evt = ((state_q == ST_READY) || (state_q == ST_SUSPEND)) &&
                      (state_d == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RESET;
      connect_q    <= 1'b0;
      disconnect_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      connect_q    <= attach_evt;
      disconnect_q <= detach_evt;
    end
  end

  usbh_frame_timer #(.TICKS_PER_FRAME(TICKS_PER_FRAME)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_READY),
    .tick_o (sof_tick_o)
  );

  assign state_o      = state_q;
  assign connect_o    = connect_q;
  assign disconnect_o = disconnect_q;

endmodule

// File: rtl/usbh_port_chk.sv
module usbh_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       dev_mode_i,
  input logic       vbus_req_i,
  input logic       sof_en_i,
  input logic [1:0] state_o,
  input logic       connect_o,
  input logic       disconnect_o,
  input logic       sof_tick_o,
  input logic       raw_line,
  input logic       line_present
);
  localparam logic [1:0] S_RST = 2'd0;
  localparam logic [1:0] S_IDL = 2'd1;
  localparam logic [1:0] S_RDY = 2'd2;
  localparam logic [1:0] S_SUS = 2'd3;

  // R1
  hold_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_RST && !(enable_i && !dev_mode_i)) |=> state_o == S_RST);

  // R2
  leave_host_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i || dev_mode_i) |=> (state_o == S_RST && !connect_o && !disconnect_o));

  // R3
  no_vbus_attach_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_IDL && !vbus_req_i) |=> state_o != S_RDY);

  // R4
  attach_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_IDL && vbus_req_i && line_present && enable_i && !dev_mode_i)
      |=> state_o == S_RDY);

  // R5
  filter_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_present != $past(line_present)) |-> ($past(raw_line) == line_present));

  // R6
  suspend_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_RDY && !sof_en_i && line_present && enable_i && !dev_mode_i)
      |=> state_o == S_SUS);

  // R7
  tick_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_tick_o |-> state_o == S_RDY);

  // R7
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_tick_o |=> !sof_tick_o);

  // R8
  connect_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    connect_o |-> (state_o == S_RDY && $past(state_o) == S_IDL));

  // R8
  disconnect_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconnect_o |-> (state_o == S_IDL && ($past(state_o) == S_RDY || $past(state_o) == S_SUS)));

  // R8
  events_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(connect_o && disconnect_o));

  // R9
  detach_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == S_RDY || state_o == S_SUS) && !line_present && enable_i && !dev_mode_i)
      |=> state_o == S_IDL);

endmodule

bind usbh_port_fsm usbh_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .dev_mode_i   (dev_mode_i),
  .vbus_req_i   (vbus_req_i),
  .sof_en_i     (sof_en_i),
  .state_o      (state_o),
  .connect_o    (connect_o),
  .disconnect_o (disconnect_o),
  .sof_tick_o   (sof_tick_o),
  .raw_line     (raw_line),
  .line_present (line_present)
);

// File: tb/sim_usbh_port_fsm.sv
`timescale 1ns/1ps
module sim_usbh_port_fsm;

  localparam int unsigned FRAME = 20;
  localparam int unsigned DEB   = 4;
  localparam int SETTLE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, dev = 1'b0, vbus = 1'b0, sof_en = 1'b1, dp = 1'b0, dm = 1'b0;
  logic [1:0] state;
  logic conn, disc, tick;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  usbh_port_fsm #(.TICKS_PER_FRAME(FRAME), .DEB_CYCLES(DEB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .dev_mode_i(dev),
    .vbus_req_i(vbus), .sof_en_i(sof_en), .dp_i(dp), .dm_i(dm),
    .state_o(state), .connect_o(conn), .disconnect_o(disc), .sof_tick_o(tick)
  );

  // [7] enable [6] device mode [5] vbus [4] sof_en [3] dp [2] dm [1:0] expected state
  localparam logic [7:0] VEC [16] = '{
    8'b0001_0000, 8'b1101_0000, 8'b1001_0001, 8'b1001_1001,
    8'b1011_1010, 8'b1010_1011, 8'b1011_1010, 8'b1011_0110,
    8'b1011_0001, 8'b1011_0110, 8'b1010_0111, 8'b1010_0001,
    8'b1011_1010, 8'b0011_1000, 8'b1011_1010, 8'b1111_1000
  };
  localparam int VREQ [16] = '{1, 2, 2, 3, 4, 6, 6, 4, 4, 4, 6, 4, 4, 2, 2, 2};

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      finish_run();
    end
  end

  // edges from now until the first tick
  task automatic first_tick_after(output int k);
    k = -1;
    for (int i = 1; i <= 2 * int'(FRAME); i++) begin
      step(1);
      if (tick && k < 0) k = i;
    end
  endtask

  initial begin
    int k, n, seen;
    // R1: reset state
    step(3);
    chk("R1", "state during reset", int'(state), 0);
    chk("R1", "events during reset", int'({conn, disc, tick}), 0);
    rst_n = 1'b1;
    step(2);
    chk("R1", "state after reset, disabled", int'(state), 0);

    // table walk
    for (int r = 0; r < 16; r++) begin
      {en, dev, vbus, sof_en, dp, dm} = VEC[r][7:2];
      step(SETTLE);
      checks++;
      if (state != VEC[r][1:0]) begin
        fails++;
        $display("FAIL R%0d table row %0d actual=%0d expected=%0d",
                 VREQ[r], r, state, VEC[r][1:0]);
      end
    end

    // R5/R8: exact attach latency and connect pulse
    rst_n = 1'b0; step(2); rst_n = 1'b1;
    {en, dev, vbus, sof_en, dp, dm} = 6'b101100;
    step(SETTLE);
    chk("R2", "idle after enable", int'(state), 1);
    dp = 1'b1;
    step(int'(DEB) + 2);
    chk("R5", "still idle one edge before window closes", int'(state), 1);
    chk("R8", "no connect yet", int'(conn), 0);
    step(1);
    chk("R5", "ready on edge DEB+3", int'(state), 2);
    chk("R8", "connect pulse", int'(conn), 1);
    // R7: first tick FRAME-1 edges after entry, then every FRAME
    k = -1; n = 0;
    for (int i = 1; i <= 3 * int'(FRAME); i++) begin
      step(1);
      if (i == 1) chk("R8", "connect lasts one cycle", int'(conn), 0);
      if (tick) begin
        if (k < 0) k = i;
        n++;
      end
    end
    chk("R7", "first tick edge after ready entry", k, int'(FRAME) - 1);
    chk("R7", "ticks in three frames", n, 3);

    // R6/R7: suspend withholds ticks, resume restarts the frame
    sof_en = 1'b0;
    step(1);
    chk("R6", "suspend after sof_en clear", int'(state), 3);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      step(1);
      if (tick) n++;
    end
    chk("R7", "ticks while suspended", n, 0);
    sof_en = 1'b1;
    step(1);
    chk("R6", "ready after sof_en set", int'(state), 2);
    first_tick_after(k);
    chk("R7", "first tick after resume", k, int'(FRAME) - 1);

    // R4/R8: detach timing and disconnect pulse
    dp = 1'b0;
    step(int'(DEB) + 2);
    chk("R5", "still attached before window closes", int'(state), 2);
    step(1);
    chk("R4", "idle after detach", int'(state), 1);
    chk("R8", "disconnect pulse", int'(disc), 1);
    step(1);
    chk("R8", "disconnect lasts one cycle", int'(disc), 0);

    // R5: short glitch rejected
    seen = 0;
    dm = 1'b1;
    step(int'(DEB) - 1);
    dm = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (conn) seen = 1;
    end
    chk("R5", "glitch keeps idle", int'(state), 1);
    chk("R5", "glitch raises no connect", seen, 0);

    // R9: detach and sof_en clear on the same edge
    dm = 1'b1;
    step(SETTLE);
    chk("R4", "ready via DM", int'(state), 2);
    dm = 1'b0;
    step(int'(DEB) + 2);
    sof_en = 1'b0;
    step(1);
    chk("R9", "detach beats suspend", int'(state), 1);
    chk("R9", "disconnect on combined edge", int'(disc), 1);
    step(1);
    chk("R9", "no suspend afterwards", int'(state), 1);

    // R2: disable while attached
    sof_en = 1'b1; dp = 1'b1;
    step(SETTLE);
    chk("R4", "ready again", int'(state), 2);
    en = 1'b0;
    step(1);
    chk("R2", "reset on disable", int'(state), 0);
    chk("R2", "no disconnect on disable", int'(disc), 0);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (tick) n++;
    end
    chk("R2", "no ticks in reset", n, 0);

    finish_run();
  end

endmodule